// File: doc/BRIEF.md
# Codec Serial Time-Slot Formatter

This block sits between a byte-wide serial port front end and the 16-bit left/right sample paths of an audio codec. Each frame carries numbered byte slots: four audio slots for the left and right channels, plus one output-setting byte. On the receive side the formatter collects the audio bytes of a frame and hands both DAC samples over together at the frame boundary. It also decodes the output-setting byte into headphone enable, line enable and attenuation. On the transmit side it answers each slot request with the matching ADC byte.

Four formats are selected by a mode input: 16-bit stereo, 16-bit mono, 8-bit stereo and 8-bit mono. Companding sits outside the block. In 8-bit modes the received code is passed on in the upper byte of the DAC sample for a downstream expander. The compressed ADC codes come in on their own ports. After reset the block reports a calibration phase for a set number of frames, and during that phase its ADC bytes read as zero.

Top module: `tsf_slot_formatter`

## Requirements
- R1: In 16-bit modes, left DAC = {slot 1 byte, slot 2 byte} and right DAC = {slot 3 byte, slot 4 byte}. On transmit, slot 1/2 return the high/low byte of the left ADC sample and slot 3/4 those of the right.
- R2: In 8-bit modes (mode[1]=1), the left DAC is {slot 1 byte, 8'h00} and the right DAC is {slot 3 byte, 8'h00}; slots 2 and 4 have no effect. On transmit, slot 1 returns the left compressed code, slot 3 the right compressed code, and slots 2 and 4 return zero.
- R3: In mono modes (mode[0]=1), the right DAC sample equals the left DAC sample.
- R4: In mono modes, transmit slots 3 and 4 return zero.
- R5: The slot 5 byte is decoded as bit 7 = headphone enable, bit 6 = line enable, bits 5..0 = attenuation. If no slot 5 arrives in a frame, the previous setting is kept.
- R6: While rst is high, the attenuation is 63, both enables are 0, both DAC samples are 0 and cal_busy is 1.
- R7: After rst falls, cal_busy stays 1 until CAL_FRAMES frame_end pulses have been seen. While cal_busy is 1, every transmit byte is zero.
- R8: Received bytes on slot 0 or on slots 6 and above change nothing. Transmit requests for those slots return zero.
- R9: DAC samples and the output setting change only on the clock edge that samples frame_end, and both channels change together.
- R10: While headphone and line enables are both 0, both DAC samples are zero.
- R11: tx_byte shows the answer to a request on the clock after tx_req, and is zero when no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 = 16-bit stereo, 1 = 16-bit mono, 2 = 8-bit stereo, 3 = 8-bit mono |
| rx_valid | input | 1 | Strobe for a received slot byte |
| rx_slot | input | SLOT_W | Slot number of the received byte |
| rx_byte | input | 8 | Received byte |
| frame_end | input | 1 | One-cycle pulse closing a frame |
| tx_req | input | 1 | Request for a transmit byte |
| tx_slot | input | SLOT_W | Slot number of the request |
| adc_left | input | 16 | Left ADC sample |
| adc_right | input | 16 | Right ADC sample |
| cmp_left | input | 8 | Compressed left ADC code |
| cmp_right | input | 8 | Compressed right ADC code |
| tx_byte | output | 8 | Transmit byte, one clock after the request |
| dac_left | output | 16 | Left DAC sample |
| dac_right | output | 16 | Right DAC sample |
| hp_en | output | 1 | Headphone enable |
| line_en | output | 1 | Line output enable |
| atten | output | 6 | Output attenuation in 1.5 dB steps |
| cal_busy | output | 1 | Calibration in progress |

## Verification
Every result of this block comes out one register deep. DAC samples and the output setting appear one clock after the cycle that holds frame_end. A transmit byte appears one clock after its request. cal_busy drops on the clock that samples the final counted frame_end. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check falls exactly one rising edge after its stimulus. It also reads the DAC outputs after all slots of a frame are sent but before frame_end, to confirm that nothing moved early.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    MODE_W16_ST   = 2'd0,
    MODE_W16_MONO = 2'd1,
    MODE_W8_ST    = 2'd2,
    MODE_W8_MONO  = 2'd3
  } fmt_mode_e;

  typedef struct packed {
    logic       hp_on;
    logic       line_on;
    logic [5:0] atten;
  } outset_t;

  localparam outset_t OUTSET_RST = '{hp_on: 1'b0, line_on: 1'b0, atten: 6'h3F};
  localparam int unsigned AUDIO_SLOTS = 4;
  localparam int unsigned CTRL_SLOT   = 5;

  function automatic logic is_mono(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic is_narrow(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/tsf_cal_timer.sv
module tsf_cal_timer #(
  parameter int unsigned CAL_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  output logic cal_busy
);
  localparam int unsigned CNT_W = $clog2(CAL_FRAMES + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= CNT_W'(CAL_FRAMES);
      cal_busy <= 1'b1;
    end else if (frame_end && left_q != '0) begin
      left_q   <= left_q - 1'b1;
      cal_busy <= (left_q != CNT_W'(1));
    end
  end

  // R7: busy only ends on a counted frame boundary
  a_r7_busy_ends_on_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_busy) |-> $past(frame_end));
  // R7: once clear, busy stays clear until reset
  a_r7_busy_no_return: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |=> !cal_busy);
endmodule

// File: rtl/tsf_rx_unpack.sv
module tsf_rx_unpack
  import tsf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                rx_valid,
  input  logic [SLOT_W-1:0]   rx_slot,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                frame_end,
  output logic [2*BYTE_W-1:0] dac_left,
  output logic [2*BYTE_W-1:0] dac_right,
  output outset_t             outset
);
  localparam int unsigned SAMPLE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] shadow [AUDIO_SLOTS];
  logic [BYTE_W-1:0] ctl_pend;
  logic              ctl_seen;

  for (genvar g = 0; g < AUDIO_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        shadow[g] <= '0;
      else if (rx_valid && rx_slot == SLOT_W'(g + 1))
        shadow[g] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_pend <= '0;
      ctl_seen <= 1'b0;
    end else if (frame_end) begin
      ctl_seen <= 1'b0;
    end else if (rx_valid && rx_slot == SLOT_W'(CTRL_SLOT)) begin
      ctl_pend <= rx_byte;
      ctl_seen <= 1'b1;
    end
  end

  logic [SAMPLE_W-1:0] nxt_l, nxt_r_st, nxt_r;
  outset_t             nxt_set;
  logic                nxt_mute;

  always_comb begin
    if (is_narrow(mode)) begin
      nxt_l    = {shadow[0], {BYTE_W{1'b0}}};
      nxt_r_st = {shadow[2], {BYTE_W{1'b0}}};
    end else begin
      nxt_l    = {shadow[0], shadow[1]};
      nxt_r_st = {shadow[2], shadow[3]};
    end
    nxt_r    = is_mono(mode) ? nxt_l : nxt_r_st;
    nxt_set  = ctl_seen ? outset_t'(ctl_pend[7:0]) : outset;
    nxt_mute = !nxt_set.hp_on && !nxt_set.line_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_left  <= '0;
      dac_right <= '0;
      outset    <= OUTSET_RST;
    end else if (frame_end) begin
      dac_left  <= nxt_mute ? '0 : nxt_l;
      dac_right <= nxt_mute ? '0 : nxt_r;
      outset    <= nxt_set;
    end
  end

  // R9: outputs only move on a frame boundary
  a_r9_atomic: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(dac_left) && $stable(dac_right) && $stable(outset)));
  // R3: mono commit duplicates left into right
  a_r3_mono_dup: assert property (@(posedge clk) disable iff (rst)
    (frame_end && is_mono(mode)) |=> (dac_right == dac_left));
  // R2: narrow commit leaves low byte clear
  a_r2_narrow_low: assert property (@(posedge clk) disable iff (rst)
    (frame_end && is_narrow(mode)) |=> (dac_left[BYTE_W-1:0] == '0));
  // R10: muted outputs present zero
  a_r10_mute_zero: assert property (@(posedge clk) disable iff (rst)
    (!outset.hp_on && !outset.line_on) |-> (dac_left == '0 && dac_right == '0));
endmodule

// File: rtl/tsf_tx_pack.sv
module tsf_tx_pack
  import tsf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                cal_busy,
  input  logic                tx_req,
  input  logic [SLOT_W-1:0]   tx_slot,
  input  logic [2*BYTE_W-1:0] adc_left,
  input  logic [2*BYTE_W-1:0] adc_right,
  input  logic [BYTE_W-1:0]   cmp_left,
  input  logic [BYTE_W-1:0]   cmp_right,
  output logic [BYTE_W-1:0]   tx_byte
);
  logic [BYTE_W-1:0] pick;
  logic              mono, narrow;

  always_comb begin
    mono   = is_mono(mode);
    narrow = is_narrow(mode);
    pick   = '0;
    if (!cal_busy) begin
      if (tx_slot == SLOT_W'(1))
        pick = narrow ? cmp_left : adc_left[2*BYTE_W-1:BYTE_W];
      else if (tx_slot == SLOT_W'(2))
        pick = narrow ? '0 : adc_left[BYTE_W-1:0];
      else if (tx_slot == SLOT_W'(3))
        pick = mono ? '0 : (narrow ? cmp_right : adc_right[2*BYTE_W-1:BYTE_W]);
      else if (tx_slot == SLOT_W'(4))
        pick = (mono || narrow) ? '0 : adc_right[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_byte <= '0;
    else     tx_byte <= tx_req ? pick : '0;
  end

  // R7: calibration forces zero transmit data
  a_r7_busy_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_req && cal_busy) |=> (tx_byte == '0));
  // R8: slots outside the audio range transmit zero
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (tx_req && (tx_slot == '0 || tx_slot > SLOT_W'(AUDIO_SLOTS))) |=> (tx_byte == '0));
  // R4: mono right slots transmit zero
  a_r4_mono_right: assert property (@(posedge clk) disable iff (rst)
    (tx_req && is_mono(mode) && (tx_slot == SLOT_W'(3) || tx_slot == SLOT_W'(4)))
      |=> (tx_byte == '0));
  // R11: idle cycles give zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !tx_req |=> (tx_byte == '0));
endmodule

// File: rtl/tsf_slot_formatter.sv
module tsf_slot_formatter
  import tsf_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned CAL_FRAMES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                rx_valid,
  input  logic [SLOT_W-1:0]   rx_slot,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                frame_end,
  input  logic                tx_req,
  input  logic [SLOT_W-1:0]   tx_slot,
  input  logic [2*BYTE_W-1:0] adc_left,
  input  logic [2*BYTE_W-1:0] adc_right,
  input  logic [BYTE_W-1:0]   cmp_left,
  input  logic [BYTE_W-1:0]   cmp_right,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic [2*BYTE_W-1:0] dac_left,
  output logic [2*BYTE_W-1:0] dac_right,
  output logic                hp_en,
  output logic                line_en,
  output logic [5:0]          atten,
  output logic                cal_busy
);
  outset_t outset;

  tsf_cal_timer #(.CAL_FRAMES(CAL_FRAMES)) u_cal (
    .clk      (clk),
    .rst      (rst),
    .frame_end(frame_end),
    .cal_busy (cal_busy)
  );

  tsf_rx_unpack #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .rx_valid (rx_valid),
    .rx_slot  (rx_slot),
    .rx_byte  (rx_byte),
    .frame_end(frame_end),
    .dac_left (dac_left),
    .dac_right(dac_right),
    .outset   (outset)
  );

  tsf_tx_pack #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .cal_busy (cal_busy),
    .tx_req   (tx_req),
    .tx_slot  (tx_slot),
    .adc_left (adc_left),
    .adc_right(adc_right),
    .cmp_left (cmp_left),
    .cmp_right(cmp_right),
    .tx_byte  (tx_byte)
  );

  assign hp_en   = outset.hp_on;
  assign line_en = outset.line_on;
  assign atten   = outset.atten;

  // R6: reset state seen one clock into reset
  a_r6_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (atten == 6'h3F && !hp_en && !line_en && cal_busy));
endmodule

// File: tb/tsf_slot_formatter_tb.sv
module tsf_slot_formatter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CALN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic rx_valid = 1'b0;
  logic [2:0] rx_slot = '0;
  logic [7:0] rx_byte = '0;
  logic frame_end = 1'b0;
  logic tx_req = 1'b0;
  logic [2:0] tx_slot = '0;
  logic [15:0] adc_left = 16'hA1B2, adc_right = 16'hC3D4;
  logic [7:0] cmp_left = 8'h5E, cmp_right = 8'h6F;
  logic [7:0] tx_byte;
  logic [15:0] dac_left, dac_right;
  logic hp_en, line_en, cal_busy;
  logic [5:0] atten;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsf_slot_formatter #(.BYTE_W(8), .SLOT_W(3), .CAL_FRAMES(CALN)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_byte(rx_byte), .frame_end(frame_end), .tx_req(tx_req), .tx_slot(tx_slot),
    .adc_left(adc_left), .adc_right(adc_right), .cmp_left(cmp_left),
    .cmp_right(cmp_right), .tx_byte(tx_byte), .dac_left(dac_left),
    .dac_right(dac_right), .hp_en(hp_en), .line_en(line_en), .atten(atten),
    .cal_busy(cal_busy)
  );

  // mode | s1 s2 s3 s4 | ctl | exp left | exp right
  localparam int NV = 6;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 32'h12345678, 8'hC0, 16'h1234, 16'h5678},
    {2'd1, 32'hABCD1122, 8'h80, 16'hABCD, 16'hABCD},
    {2'd2, 32'h9A773C55, 8'h45, 16'h9A00, 16'h3C00},
    {2'd3, 32'h0FEE9988, 8'h40, 16'h0F00, 16'h0F00},
    {2'd0, 32'hFF008001, 8'h00, 16'h0000, 16'h0000},
    {2'd0, 32'h0001FEFF, 8'hFF, 16'h0001, 16'hFEFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] s, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_slot = s; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic close_frame();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic ask(input logic [2:0] s, input string req, input logic [7:0] exp);
    @(negedge clk);
    tx_req = 1'b1; tx_slot = s;
    @(negedge clk);
    tx_req = 1'b0;
    chk(req, {24'h0, tx_byte}, {24'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pl, pr;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 atten", {26'h0, atten}, 32'h3F);
    chk("R6 enables", {30'h0, hp_en, line_en}, 32'h0);
    chk("R6 dac", {dac_left, dac_right}, 32'h0);
    chk("R6 busy", {31'h0, cal_busy}, 32'h1);
    rst = 1'b0;
    // R7: transmit zero while calibrating
    ask(3'd1, "R7 busy tx", 8'h00);
    for (int i = 0; i < CALN - 1; i++) close_frame();
    chk("R7 busy before last frame", {31'h0, cal_busy}, 32'h1);
    close_frame();
    chk("R7 busy cleared", {31'h0, cal_busy}, 32'h0);

    pl = 16'h0; pr = 16'h0;
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][73:72];
      for (int s = 0; s < 4; s++) send(3'(s + 1), VEC[v][71 - 8*s -: 8]);
      send(3'd5, VEC[v][39:32]);
      // R9: nothing moves before frame_end
      chk("R9 hold before frame", {dac_left, dac_right}, {pl, pr});
      close_frame();
      chk("R1 R2 R3 R10 dac", {dac_left, dac_right}, {VEC[v][31:16], VEC[v][15:0]});
      chk("R5 slot5 decode", {24'h0, hp_en, line_en, atten}, {24'h0, VEC[v][39:32]});
      pl = VEC[v][31:16]; pr = VEC[v][15:0];
    end

    // R8: slots 0 and 6 ignored; no slot 5 keeps setting (R5)
    send(3'd6, 8'h55);
    send(3'd0, 8'h66);
    send(3'd7, 8'h77);
    close_frame();
    chk("R8 rx ignored", {dac_left, dac_right}, 32'h0001FEFF);
    chk("R5 setting kept", {24'h0, hp_en, line_en, atten}, 32'hFF);

    // transmit in each mode (R1 R2 R4 R11)
    mode = 2'd0;
    ask(3'd1, "R1 tx s1", 8'hA1);
    ask(3'd2, "R1 tx s2", 8'hB2);
    ask(3'd3, "R1 tx s3", 8'hC3);
    ask(3'd4, "R1 tx s4", 8'hD4);
    ask(3'd6, "R8 tx s6", 8'h00);
    ask(3'd0, "R8 tx s0", 8'h00);
    @(negedge clk);
    chk("R11 idle zero", {24'h0, tx_byte}, 32'h0);
    mode = 2'd1;
    ask(3'd1, "R4 mono s1", 8'hA1);
    ask(3'd3, "R4 mono s3", 8'h00);
    ask(3'd4, "R4 mono s4", 8'h00);
    mode = 2'd2;
    ask(3'd1, "R2 tx code l", 8'h5E);
    ask(3'd2, "R2 tx s2", 8'h00);
    ask(3'd3, "R2 tx code r", 8'h6F);
    mode = 2'd3;
    ask(3'd1, "R2 mono code l", 8'h5E);
    ask(3'd3, "R4 narrow mono s3", 8'h00);

    // R6: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R6 rerst atten", {26'h0, atten}, 32'h3F);
    chk("R6 rerst mute dac", {hp_en, line_en, dac_left, dac_right}, 34'h0);
    chk("R6 rerst busy", {31'h0, cal_busy}, 32'h1);
    rst = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule